// File: doc/BRIEF.md
# Unaligned Load Pair Extractor

This block is the data path of a load unit that builds a misaligned read out of two aligned word reads. Each request carries two address operands that are added together, an access width of 1, 2, 4 or 8 bytes, a sign-extension select and a request kind. A plain request reads one aligned word and faults if the address is not a multiple of the access width. A low-half request reads the word that holds the first byte of the access. A high-half request reads the following word. It takes the earlier low-half result as an extra operand and picks the requested bytes out of the 128-bit pair.

A high-half request whose bytes all sit inside the low word makes no memory read. This matters at the end of a mapped region, where the next word may not exist. The block drives a simple memory port with one request strobe and a word address. It expects read data exactly one cycle later. Each accepted request produces one result cycle carrying a full 64-bit value, which never merges with an old destination.

Top module: `ulp_load_unit`

## Requirements
- R1: The effective address is `in_base + in_index` modulo 2^64. A plain or low-half request that reads memory raises `mem_req` in the same cycle as `in_valid`, with `mem_addr` set to the effective address with bits [2:0] cleared.
- R2: `in_kind` is encoded as 0 = plain, 1 = low half, 2 = high half. The reserved value 3 behaves exactly as a plain request, including the misalignment fault.
- R3: A low-half request returns the whole aligned 64-bit word read from memory, unchanged, whatever its size or sign select.
- R4: A high-half request whose bytes spill past the low word reads at the effective address rounded down to 8 plus 8. It returns the bytes of `{mem_rdata, in_prev}`, starting at byte offset `addr[2:0]`; byte k of the result is byte `offset+k` of that pair.
- R5: The data spills when `addr[2:0] + 2^in_size > 8`. A high-half request that does not spill raises no `mem_req`. Its bytes come only from `in_prev`, and `out_valid` rises one cycle after `in_valid`.
- R6: With `in_sext` = 0, every result byte above the access width is zero.
- R7: With `in_sext` = 1, every result bit above the access width copies the top bit of the loaded value.
- R8: A plain request whose address is not a multiple of `2^in_size` raises no `mem_req`. One cycle later it gives `out_valid` = 1 with `out_fault` = 1 and `out_data` = 0. Low-half and high-half requests never fault.
- R9: For a request that reads memory, the result appears with `out_valid` in the cycle that `mem_rvalid` is high, one cycle after `mem_req`. A plain request returns the `2^in_size` bytes starting at the offset, extended to 64 bits.
- R10: In and after reset, with no request presented, `out_valid` and `mem_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_base | input | 64 | First address operand |
| in_index | input | 64 | Second address operand |
| in_size | input | 2 | Access width as log2 of the byte count |
| in_sext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| in_kind | input | 2 | Request kind: 0 plain, 1 low half, 2 high half, 3 reserved |
| in_prev | input | 64 | Low-half result, used by high-half requests |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 64 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid, one cycle after the strobe |
| mem_rdata | input | 64 | Read data |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Extended result |
| out_fault | output | 1 | Misaligned plain request |

## Verification
A wrong spill decision shows up in the request cycle itself. Either a high-half read is issued when it must not be, or a result arrives with stale bytes from `in_prev`. A wrongly held kind, offset or size in the pending stage shows up one cycle later, as misplaced or badly extended bytes on `out_data`. A bad fault decision shows up in both cycles: a read strobe that should be absent, then a result that is nonzero or unflagged. Every stimulus uses memory bytes and operand bytes that are distinct and include high-bit values, so a one-byte shift error or a wrong fill byte changes the compared value.

// File: rtl/ulp_pkg.sv
package ulp_pkg;
  typedef enum logic [1:0] {
    LK_PLAIN = 2'd0,
    LK_LO    = 2'd1,
    LK_HI    = 2'd2,
    LK_RSVD  = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/ulp_addr_gen.sv
module ulp_addr_gen
  import ulp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int WORD_BYTES = 8,
  parameter int OFF_W      = 3,
  parameter int SIZE_W     = 2
) (
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        kind,
  output logic [OFF_W-1:0]  offset,
  output ld_kind_e          kind_norm,
  output logic              spill,
  output logic              misalign,
  output logic              use_mem,
  output logic              fault,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int CNT_W = OFF_W + 2;

  function automatic logic [ADDR_W-1:0] f_eff_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [CNT_W-1:0] f_nbytes(input logic [SIZE_W-1:0] s);
    return CNT_W'(1) << s;
  endfunction

  function automatic logic f_spills(input logic [OFF_W-1:0] off, input logic [SIZE_W-1:0] s);
    return ({2'b00, off} + f_nbytes(s)) > CNT_W'(WORD_BYTES);
  endfunction

  function automatic logic f_misaligned(input logic [OFF_W-1:0] off, input logic [SIZE_W-1:0] s);
    return ({2'b00, off} & (f_nbytes(s) - CNT_W'(1))) != '0;
  endfunction

  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] line_addr;
  logic              is_hi, is_lo;

  assign ea        = f_eff_addr(base, index);
  assign offset    = ea[OFF_W-1:0];
  assign line_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign is_hi     = (ld_kind_e'(kind) == LK_HI);
  assign is_lo     = (ld_kind_e'(kind) == LK_LO);
  assign kind_norm = is_hi ? LK_HI : (is_lo ? LK_LO : LK_PLAIN);
  assign spill     = f_spills(offset, size);
  assign misalign  = f_misaligned(offset, size);

  always_comb begin
    if (is_lo)      use_mem = in_valid;
    else if (is_hi) use_mem = in_valid && spill;
    else            use_mem = in_valid && !misalign;
  end

  assign fault    = in_valid && !is_lo && !is_hi && misalign;
  assign req_addr = is_hi ? (line_addr + ADDR_W'(WORD_BYTES)) : line_addr;
endmodule

// File: rtl/ulp_req_stage.sv
module ulp_req_stage
  import ulp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  ld_kind_e          d_kind,
  input  logic [OFF_W-1:0]  d_off,
  input  logic [SIZE_W-1:0] d_size,
  input  logic              d_sext,
  input  logic [DATA_W-1:0] d_prev,
  input  logic              d_mem,
  input  logic              d_fault,
  output logic              q_valid,
  output ld_kind_e          q_kind,
  output logic [OFF_W-1:0]  q_off,
  output logic [SIZE_W-1:0] q_size,
  output logic              q_sext,
  output logic [DATA_W-1:0] q_prev,
  output logic              q_mem,
  output logic              q_fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_kind  <= LK_PLAIN;
      q_off   <= '0;
      q_size  <= '0;
      q_sext  <= 1'b0;
      q_prev  <= '0;
      q_mem   <= 1'b0;
      q_fault <= 1'b0;
    end else begin
      q_valid <= d_valid;
      q_mem   <= d_valid && d_mem;
      q_fault <= d_valid && d_fault;
      if (d_valid) begin
        q_kind <= d_kind;
        q_off  <= d_off;
        q_size <= d_size;
        q_sext <= d_sext;
        q_prev <= d_prev;
      end
    end
  end
endmodule

// File: rtl/ulp_extract.sv
module ulp_extract #(
  parameter int WORD_BYTES = 8,
  parameter int OFF_W      = 3,
  parameter int SIZE_W     = 2
) (
  input  logic [WORD_BYTES*8-1:0] lo_word,
  input  logic [WORD_BYTES*8-1:0] hi_word,
  input  logic [OFF_W-1:0]        offset,
  input  logic [SIZE_W-1:0]       size,
  input  logic                    sext,
  output logic [WORD_BYTES*8-1:0] data
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int CNT_W  = OFF_W + 2;

  function automatic logic [CNT_W-1:0] f_nbytes(input logic [SIZE_W-1:0] s);
    return CNT_W'(1) << s;
  endfunction

  logic [2*DATA_W-1:0] window;
  logic [2*DATA_W-1:0] shifted;
  logic [CNT_W-1:0]    nb;
  logic                sign_bit;
  logic [7:0]          fill;

  assign window  = {hi_word, lo_word};
  assign shifted = window >> {offset, 3'b000};
  assign nb      = f_nbytes(size);

  always_comb begin
    sign_bit = 1'b0;
    for (int b = 1; b <= WORD_BYTES; b++) begin
      if (nb == CNT_W'(b)) sign_bit = shifted[8*b-1];
    end
  end

  assign fill = (sext && sign_bit) ? 8'hFF : 8'h00;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign data[8*g +: 8] = (CNT_W'(g) < nb) ? shifted[8*g +: 8] : fill;
  end
endmodule

// File: rtl/ulp_load_unit.sv
module ulp_load_unit
  import ulp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [ADDR_W-1:0]                 in_base,
  input  logic [ADDR_W-1:0]                 in_index,
  input  logic [$clog2($clog2(WORD_BYTES)+1)-1:0] in_size,
  input  logic                              in_sext,
  input  logic [1:0]                        in_kind,
  input  logic [WORD_BYTES*8-1:0]           in_prev,
  output logic                              mem_req,
  output logic [ADDR_W-1:0]                 mem_addr,
  input  logic                              mem_rvalid,
  input  logic [WORD_BYTES*8-1:0]           mem_rdata,
  output logic                              out_valid,
  output logic [WORD_BYTES*8-1:0]           out_data,
  output logic                              out_fault
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int OFF_W  = $clog2(WORD_BYTES);
  localparam int SIZE_W = $clog2(OFF_W + 1);

  logic [OFF_W-1:0]  ag_offset;
  ld_kind_e          ag_kind;
  logic              ag_spill, ag_misalign, ag_use_mem, ag_fault;
  logic [ADDR_W-1:0] ag_req_addr;

  ulp_addr_gen #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_agen (
    .in_valid (in_valid),
    .base     (in_base),
    .index    (in_index),
    .size     (in_size),
    .kind     (in_kind),
    .offset   (ag_offset),
    .kind_norm(ag_kind),
    .spill    (ag_spill),
    .misalign (ag_misalign),
    .use_mem  (ag_use_mem),
    .fault    (ag_fault),
    .req_addr (ag_req_addr)
  );

  assign mem_req  = ag_use_mem;
  assign mem_addr = ag_req_addr;

  logic              pend_valid, pend_sext, pend_mem, pend_fault;
  ld_kind_e          pend_kind;
  logic [OFF_W-1:0]  pend_off;
  logic [SIZE_W-1:0] pend_size;
  logic [DATA_W-1:0] pend_prev;

  ulp_req_stage #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_valid(in_valid),
    .d_kind (ag_kind),
    .d_off  (ag_offset),
    .d_size (in_size),
    .d_sext (in_sext),
    .d_prev (in_prev),
    .d_mem  (ag_use_mem),
    .d_fault(ag_fault),
    .q_valid(pend_valid),
    .q_kind (pend_kind),
    .q_off  (pend_off),
    .q_size (pend_size),
    .q_sext (pend_sext),
    .q_prev (pend_prev),
    .q_mem  (pend_mem),
    .q_fault(pend_fault)
  );

  logic              pend_is_hi, pend_is_lo;
  logic [DATA_W-1:0] ex_lo, ex_hi, ex_data;
  logic [OFF_W-1:0]  ex_off;
  logic [SIZE_W-1:0] ex_size;

  assign pend_is_hi = (pend_kind == LK_HI);
  assign pend_is_lo = (pend_kind == LK_LO);
  assign ex_lo      = pend_is_hi ? pend_prev : mem_rdata;
  assign ex_hi      = (pend_is_hi && pend_mem) ? mem_rdata : '0;
  assign ex_off     = pend_is_lo ? '0 : pend_off;
  assign ex_size    = pend_is_lo ? SIZE_W'(OFF_W) : pend_size;

  ulp_extract #(
    .WORD_BYTES(WORD_BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_extract (
    .lo_word(ex_lo),
    .hi_word(ex_hi),
    .offset (ex_off),
    .size   (ex_size),
    .sext   (pend_sext),
    .data   (ex_data)
  );

  assign out_valid = pend_valid && (!pend_mem || mem_rvalid);
  assign out_fault = out_valid && pend_fault;
  assign out_data  = (out_valid && !pend_fault) ? ex_data : '0;
endmodule

// File: rtl/ulp_load_unit_chk.sv
module ulp_load_unit_chk #(
  parameter int ADDR_W     = 64,
  parameter int WORD_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              in_kind,
  input logic                    mem_req,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    out_valid,
  input logic                    out_fault,
  input logic [WORD_BYTES*8-1:0] out_data,
  input logic                    ag_spill,
  input logic                    ag_misalign
);
  localparam int OFF_W = $clog2(WORD_BYTES);

  // R1
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  // R1
  req_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> in_valid);

  // R5
  hi_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd2 && !ag_spill) |-> !mem_req);

  // R5
  skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mem_req) |=> out_valid);

  // R2
  fault_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_kind == 2'd0 || in_kind == 2'd3) && ag_misalign) |-> !mem_req);

  // R8
  half_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_kind == 2'd1 || in_kind == 2'd2)) |=> !out_fault);

  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (out_valid && out_data == '0));

  // R10
  out_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

bind ulp_load_unit ulp_load_unit_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .out_valid  (out_valid),
  .out_fault  (out_fault),
  .out_data   (out_data),
  .ag_spill   (ag_spill),
  .ag_misalign(ag_misalign)
);

// File: tb/ulp_load_unit_tb.sv
`timescale 1ns/1ps
module ulp_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_base = '0, in_index = '0, in_prev = '0;
  logic [1:0]  in_size = '0, in_kind = '0;
  logic        in_sext = 1'b0;
  logic        mem_req, mem_rvalid;
  logic [63:0] mem_addr, mem_rdata;
  logic        out_valid, out_fault;
  logic [63:0] out_data;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ulp_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
    .in_index(in_index), .in_size(in_size), .in_sext(in_sext), .in_kind(in_kind),
    .in_prev(in_prev), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_fault(out_fault)
  );

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd29;
    return r + 8'd17;
  endfunction

  function automatic logic [63:0] mword(input logic [63:0] line);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = mbyte(line + 64'(i));
    return w;
  endfunction

  // memory with one-cycle read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem_req ? mword(mem_addr) : 64'hDEAD_BEEF_0BAD_F00D;
    end
  end

  function automatic logic [63:0] ref_data(input logic [63:0] base, input logic [63:0] idx,
                                           input logic [1:0] sz, input logic sx,
                                           input logic [1:0] kind, input logic [63:0] prev);
    logic [63:0] ea, a, r;
    int n;
    ea = base + idx;
    if (kind == 2'd1) return mword({ea[63:3], 3'b000});
    n = 1 << sz;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        a = ea + 64'(i);
        if (kind == 2'd2 && a[63:3] == ea[63:3]) r[8*i +: 8] = prev[8*a[2:0] +: 8];
        else r[8*i +: 8] = mbyte(a);
      end else begin
        r[8*i +: 8] = (sx && r[8*n-1]) ? 8'hFF : 8'h00;
      end
    end
    return r;
  endfunction

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] idx;
    logic [1:0]  sz;
    logic        sx;
    logic [1:0]  kind;
    logic        req;
    logic        flt;
  } vec_t;

  localparam logic [63:0] PREV = 64'hC3B2_A190_8F7E_6D5C;

  localparam vec_t VECS [16] = '{
    '{64'h100, 64'h8, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0},                 // R9 plain 8B
    '{64'h40,  64'h6, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0},                 // R7 plain 2B sext
    '{64'h40,  64'h2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1},                 // R8 misaligned 4B
    '{64'h50,  64'h5, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0},                 // R6 plain 1B zext
    '{64'h70,  64'hD, 2'd2, 1'b0, 2'd1, 1'b1, 1'b0},                 // R3 lo raw word
    '{64'h70,  64'hD, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0},                 // R4 hi spill
    '{64'h90,  64'h3, 2'd3, 1'b1, 2'd2, 1'b1, 1'b0},                 // R4 hi 8B sext
    '{64'h70,  64'hA, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0},                 // R5 hi no spill
    '{64'h60,  64'h4, 2'd2, 1'b1, 2'd2, 1'b0, 1'b0},                 // R5 offset+size==8
    '{64'h20,  64'h7, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0},                 // R5 last byte only
    '{64'h20,  64'hF, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0},                 // R4 offset 7 2B
    '{64'h30,  64'h1, 2'd1, 1'b0, 2'd3, 1'b0, 1'b1},                 // R2 reserved faults
    '{64'h100, 64'h4, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1},                 // R8 misaligned 8B
    '{64'h88,  64'h1, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0},                 // R3 lo ignores sext
    '{64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0}, // R1 sum wraps
    '{64'h48,  64'h0, 2'd3, 1'b0, 2'd2, 1'b0, 1'b0}                  // R5 hi full word
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R9";  1: return "R7";  2: return "R8";  3: return "R6";
      4: return "R3";  5: return "R4";  6: return "R4";  7: return "R5";
      8: return "R5";  9: return "R5";  10: return "R4"; 11: return "R2";
      12: return "R8"; 13: return "R3"; 14: return "R1"; default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    logic [63:0] ea, exp_addr, exp_d;
    v = VECS[i];
    ea = v.base + v.idx;
    exp_addr = {ea[63:3], 3'b000} + ((v.kind == 2'd2) ? 64'd8 : 64'd0);
    exp_d = v.flt ? 64'd0 : ref_data(v.base, v.idx, v.sz, v.sx, v.kind, PREV);
    @(negedge clk);
    in_valid = 1'b1; in_base = v.base; in_index = v.idx; in_size = v.sz;
    in_sext = v.sx; in_kind = v.kind; in_prev = PREV;
    #1;
    chk(tag_of(i), "mem_req", 64'(mem_req), 64'(v.req));
    if (v.req) chk("R1", "mem_addr", mem_addr, exp_addr);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R9", "out_valid", 64'(out_valid), 64'd1);
    chk(tag_of(i), "out_fault", 64'(out_fault), 64'(v.flt));
    chk(tag_of(i), "out_data", out_data, exp_d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10", "mem_req in reset", 64'(mem_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10", "out_valid idle", 64'(out_valid), 64'd0);
    chk("R10", "mem_req idle", 64'(mem_req), 64'd0);

    for (int i = 0; i < 16; i++) run_vec(i);

    // R5: skipped high half must not leave a result pending afterwards
    @(negedge clk);
    #1;
    chk("R5", "out_valid after skip", 64'(out_valid), 64'd0);

    // R3: low half on a line containing 0x80+ bytes, whole word returned
    @(negedge clk);
    in_valid = 1'b1; in_base = 64'h1F8; in_index = 64'h3; in_size = 2'd0;
    in_sext = 1'b1; in_kind = 2'd1; in_prev = '0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R3", "lo word", out_data, mword(64'h1F8));

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule